// File: doc/BRIEF.md
# OFDM Guard Interval Inserter

This block sits after the inverse transform of an OFDM transmitter. It takes time-domain symbols of `N_PT` complex samples, 64 by default, and sends each one out again with a guard interval of `CP_LEN` samples in front, 16 by default. The guard interval is a copy of the symbol's own tail. A symbol therefore leaves as `N_PT + CP_LEN` beats, which is 80 by default. At a 20 MHz sample rate one output symbol lasts 4 us.

The prefix needs the final samples of a symbol before the first sample can be sent, so the block stores each whole symbol before it emits anything. Two symbol banks alternate. While one bank is being emitted, the next symbol is written into the other bank.

Both sides use valid/ready streaming. A beat transfers on a rising clock edge where valid and ready are both high.
- On the input side, `in_ready` falls only when both banks hold complete symbols that have not yet been fully emitted. A source may keep `in_valid` high for as long as it likes.
- On the output side, the block keeps `out_valid` high and keeps the beat unchanged until `out_ready` accepts it. A consumer may hold `out_ready` low for any length of time without losing data.

Top module: `ofdm_guard_inserter`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `out_valid` is 0 and `in_ready` is 1.
- R2: Each stored symbol leaves as `N_PT + CP_LEN` beats, with I and Q values unchanged. For the defaults the order is input samples 48..63 and then 0..63, where sample 0 is the first accepted sample of the symbol.
- R3: `out_sos` is 1 on the first prefix beat of every output symbol and 0 on every other valid beat.
- R4: `out_valid` goes high one cycle after the edge that accepts the `N_PT`-th sample of a symbol, provided no earlier symbol is still pending. It is never high while no complete symbol is stored.
- R5: `in_ready` is 0 only while two complete symbols are stored and not yet fully emitted. A symbol can therefore be accepted while the previous one is being emitted.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_i`, `out_q` and `out_sos` keep their values on the next cycle. Samples offered with `in_valid` at 0 are not stored.
- R7: A sample accepted with `in_first` at 1 becomes sample 0 of the symbol being filled, and any partly filled samples before it are discarded.
- R8: Symbols leave in the order in which they were completed at the input.
- R9: When the last beat of a stored symbol is accepted while `in_ready` is 0, `in_ready` is 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An input sample is offered |
| in_ready | output | 1 | The block can accept a sample |
| in_first | input | 1 | The offered sample is sample 0 of a symbol |
| in_i | input | SW | In-phase part of the sample, signed |
| in_q | input | SW | Quadrature part of the sample, signed |
| out_valid | output | 1 | An output beat is offered |
| out_ready | input | 1 | The consumer accepts the beat |
| out_sos | output | 1 | The beat is the first prefix beat of a symbol |
| out_i | output | SW | In-phase part of the output beat, signed |
| out_q | output | SW | Quadrature part of the output beat, signed |

## Verification
The bench builds the block with its default parameters: 64 samples per symbol, a 16-sample prefix and 12-bit I/Q. With these values a full 80-beat symbol, including the jump from the tail index 63 back to index 0, stays short enough to check many times. Holding the consumer off for a while fills both banks, and releasing it shows the exact cycle in which the input reopens. Those settings also leave room for random stalls on both sides and for a symbol that is abandoned part way and realigned by `in_first`.

// File: rtl/ofdm_gi_pkg.sv
package ofdm_gi_pkg;

  // Maps an output beat position to the stored sample index.
  // The first g beats are the prefix taken from the tail of the symbol;
  // the rest walk the symbol from index 0.
  function automatic int unsigned src_index(input int unsigned pos,
                                            input int unsigned n,
                                            input int unsigned g);
    return (pos < g) ? (pos + n - g) : (pos - g);
  endfunction

endpackage

// File: rtl/gi_fill_ctrl.sv
module gi_fill_ctrl #(
  parameter int N_PT = 64,
  localparam int AW = $clog2(N_PT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_first,
  input  logic [1:0]    bank_full,
  output logic          in_ready,
  output logic          wr_en,
  output logic          wr_bank,
  output logic [AW-1:0] wr_addr,
  output logic          fill_done
);

  logic [AW-1:0] cnt_q;
  logic          bank_q;
  logic          last;

  // The bank being filled is busy only when both banks hold pending symbols.
  assign in_ready  = !bank_full[bank_q];
  assign wr_en     = in_valid && in_ready;
  assign wr_bank   = bank_q;
  assign wr_addr   = in_first ? '0 : cnt_q;
  assign last      = (wr_addr == AW'(N_PT - 1));
  assign fill_done = wr_en && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bank_q <= 1'b0;
    end else if (wr_en) begin
      if (last) begin
        cnt_q  <= '0;
        bank_q <= !bank_q;
      end else begin
        cnt_q <= wr_addr + AW'(1);
      end
    end
  end

endmodule

// File: rtl/gi_store.sv
module gi_store #(
  parameter int N_PT = 64,
  parameter int SW   = 12,
  localparam int AW  = $clog2(N_PT)
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic                 wr_bank,
  input  logic [AW-1:0]        wr_addr,
  input  logic signed [SW-1:0] wr_i,
  input  logic signed [SW-1:0] wr_q,
  input  logic                 rd_bank,
  input  logic [AW-1:0]        rd_addr,
  output logic signed [SW-1:0] rd_i,
  output logic signed [SW-1:0] rd_q
);

  logic [2*SW-1:0] bank_word [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [2*SW-1:0] mem [N_PT];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == 1'(b))) mem[wr_addr] <= {wr_i, wr_q};
    end

    assign bank_word[b] = mem[rd_addr];
  end

  assign rd_i = bank_word[rd_bank][2*SW-1:SW];
  assign rd_q = bank_word[rd_bank][SW-1:0];

endmodule

// File: rtl/gi_drain_ctrl.sv
module gi_drain_ctrl
  import ofdm_gi_pkg::*;
#(
  parameter int N_PT   = 64,
  parameter int CP_LEN = 16,
  localparam int TOT = N_PT + CP_LEN,
  localparam int AW  = $clog2(N_PT),
  localparam int PW  = $clog2(TOT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bank_full,
  input  logic          out_ready,
  output logic          out_valid,
  output logic          out_sos,
  output logic          rd_bank,
  output logic [AW-1:0] rd_addr,
  output logic          drain_done
);

  logic [PW-1:0] pos_q;
  logic          bank_q;
  logic          last;
  logic          fire;

  assign out_valid  = bank_full[bank_q];
  assign out_sos    = out_valid && (pos_q == '0);
  assign rd_bank    = bank_q;
  assign rd_addr    = AW'(src_index(32'(pos_q), N_PT, CP_LEN));
  assign last       = (pos_q == PW'(TOT - 1));
  assign fire       = out_valid && out_ready;
  assign drain_done = fire && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= '0;
      bank_q <= 1'b0;
    end else if (fire) begin
      if (last) begin
        pos_q  <= '0;
        bank_q <= !bank_q;
      end else begin
        pos_q <= pos_q + PW'(1);
      end
    end
  end

endmodule

// File: rtl/ofdm_guard_inserter.sv
module ofdm_guard_inserter #(
  parameter int N_PT   = 64,
  parameter int CP_LEN = 16,
  parameter int SW     = 12,
  localparam int AW = $clog2(N_PT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_first,
  input  logic signed [SW-1:0] in_i,
  input  logic signed [SW-1:0] in_q,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 out_sos,
  output logic signed [SW-1:0] out_i,
  output logic signed [SW-1:0] out_q
);

  logic [1:0]    full_q;
  logic          wr_en, wr_bank, fill_done;
  logic [AW-1:0] wr_addr;
  logic          rd_bank, drain_done;
  logic [AW-1:0] rd_addr;

  gi_fill_ctrl #(.N_PT(N_PT)) u_fill (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .bank_full(full_q), .in_ready(in_ready), .wr_en(wr_en),
    .wr_bank(wr_bank), .wr_addr(wr_addr), .fill_done(fill_done)
  );

  gi_store #(.N_PT(N_PT), .SW(SW)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .wr_i(in_i), .wr_q(in_q), .rd_bank(rd_bank), .rd_addr(rd_addr),
    .rd_i(out_i), .rd_q(out_q)
  );

  gi_drain_ctrl #(.N_PT(N_PT), .CP_LEN(CP_LEN)) u_drain (
    .clk(clk), .rst_n(rst_n), .bank_full(full_q), .out_ready(out_ready),
    .out_valid(out_valid), .out_sos(out_sos), .rd_bank(rd_bank),
    .rd_addr(rd_addr), .drain_done(drain_done)
  );

  // Occupancy flag per bank: set when the fill side completes it,
  // cleared when the drain side has sent its last beat.
  for (genvar b = 0; b < 2; b++) begin : g_full
    always_ff @(posedge clk) begin
      if (!rst_n)                              full_q[b] <= 1'b0;
      else if (fill_done && wr_bank == 1'(b))  full_q[b] <= 1'b1;
      else if (drain_done && rd_bank == 1'(b)) full_q[b] <= 1'b0;
    end
  end

endmodule

// File: rtl/gi_checker.sv
module gi_checker #(
  parameter int N_PT   = 64,
  parameter int CP_LEN = 16,
  parameter int SW     = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 in_first,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic                 out_sos,
  input logic signed [SW-1:0] out_i,
  input logic signed [SW-1:0] out_q
);

  localparam int unsigned TOT = N_PT + CP_LEN;

  int unsigned fill_cnt, beat_cnt, occ, nxt_fill;
  logic in_done, out_done;

  // Track stored symbols from port handshakes alone.
  always_comb begin
    nxt_fill = in_first ? 1 : fill_cnt + 1;
    in_done  = in_valid && in_ready && (nxt_fill == N_PT);
    out_done = out_valid && out_ready && (beat_cnt == TOT - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_cnt <= 0;
      beat_cnt <= 0;
      occ      <= 0;
    end else begin
      if (in_valid && in_ready) fill_cnt <= in_done ? 0 : nxt_fill;
      if (out_valid && out_ready) beat_cnt <= out_done ? 0 : beat_cnt + 1;
      occ <= occ + (in_done ? 1 : 0) - (out_done ? 1 : 0);
    end
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_i) && $stable(out_q) && $stable(out_sos));

  assert_sos_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sos == (beat_cnt == 0)));

  assert_no_empty_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    occ == 0 |-> !out_valid);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= 2);

  assert_stall_only_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> occ == 2 && out_valid);

  assert_reopen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_done && !in_ready |=> in_ready);

endmodule

bind ofdm_guard_inserter gi_checker #(.N_PT(N_PT), .CP_LEN(CP_LEN), .SW(SW)) u_gi_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_first(in_first), .out_valid(out_valid), .out_ready(out_ready),
  .out_sos(out_sos), .out_i(out_i), .out_q(out_q)
);

// File: tb/ofdm_guard_inserter_test.sv
module ofdm_guard_inserter_test;
  localparam int NP = 64, GL = 16, SW = 12, TOT = NP + GL;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic in_valid = 1'b0, in_first = 1'b0, out_ready = 1'b0;
  logic signed [SW-1:0] in_i = '0, in_q = '0;
  logic in_ready, out_valid, out_sos;
  logic signed [SW-1:0] out_i, out_q;

  ofdm_guard_inserter #(.N_PT(NP), .CP_LEN(GL), .SW(SW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_first(in_first), .in_i(in_i), .in_q(in_q), .out_valid(out_valid),
    .out_ready(out_ready), .out_sos(out_sos), .out_i(out_i), .out_q(out_q)
  );

  int vectors = 0, errs = 0, cyc = 0, rdy_mode = 0;
  string phase = "R1";
  logic [2*SW-1:0] exp_q[$], part[$];
  logic acc_flag = 1'b0, stall_flag = 1'b0;
  logic m_ready, m_valid;
  logic prev_valid = 1'b0, prev_sos;
  logic signed [SW-1:0] prev_i, prev_q;

  function automatic int held();
    return (exp_q.size() + TOT - 1) / TOT;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s (phase %s) actual=%0d expected=%0d at cycle %0d", tag, phase, act, exp, cyc);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge.
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      exp_q.delete(); part.delete(); acc_flag = 1'b0; stall_flag = 1'b0;
    end else begin
      m_ready = (held() < 2);
      m_valid = (exp_q.size() > 0);
      stall_flag = m_valid && !out_ready;
      acc_flag = in_valid && m_ready;
      if (m_valid && out_ready) void'(exp_q.pop_front());
      if (acc_flag) begin
        if (in_first) part.delete();
        part.push_back({in_i, in_q});
        if (part.size() == NP) begin
          for (int k = NP - GL; k < NP; k++) exp_q.push_back(part[k]);
          for (int k = 0; k < NP; k++) exp_q.push_back(part[k]);
          part.delete();
        end
      end
    end
  end

  // Compare against the model on every falling edge.
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_valid = 1'b0;
    end else begin
      check(in_ready == (held() < 2), "R5 R9 in_ready", in_ready, held() < 2);
      check(out_valid == (exp_q.size() > 0), "R4 out_valid", out_valid, exp_q.size() > 0);
      if (exp_q.size() > 0) begin
        check(out_sos == (exp_q.size() % TOT == 0), "R3 out_sos", out_sos, exp_q.size() % TOT == 0);
        check({out_i, out_q} == exp_q[0], "R2 R8 data", {out_i, out_q}, exp_q[0]);
      end
      if (stall_flag && prev_valid)
        check(out_i == prev_i && out_q == prev_q && out_sos == prev_sos && out_valid,
              "R6 hold", {out_i, out_q}, {prev_i, prev_q});
      prev_valid = out_valid; prev_i = out_i; prev_q = out_q; prev_sos = out_sos;
    end
  end

  // Consumer ready pattern: 0 hold off, 1 always ready, 2 random.
  always @(negedge clk) begin
    case (rdy_mode)
      0: out_ready <= 1'b0;
      1: out_ready <= 1'b1;
      default: out_ready <= ($urandom % 3) != 0;
    endcase
  end

  task automatic send_sym(input int tag, input int len, input bit first, input int gap);
    @(negedge clk);
    for (int k = 0; k < len; k++) begin
      in_valid = 1'b1;
      in_first = first && (k == 0);
      in_i = SW'(tag * 53 + k * 7 - 900);
      in_q = SW'(tag * 11 - k * 29 + 1500);
      do @(negedge clk); while (!acc_flag);
      for (int g = 0; g < gap; g++) begin
        in_valid = 1'b0;
        in_first = 1'b1;
        in_i = SW'(-1);
        in_q = SW'(k);
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    in_first = 1'b0;
  endtask

  task automatic wait_empty();
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errs++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  initial begin
    phase = "R1";
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1 after reset", {out_valid, in_ready}, 2'b01);

    phase = "R2 R4 single";
    rdy_mode = 1;
    send_sym(1, NP, 1'b1, 0);
    wait_empty();

    phase = "R5 R9 saturate";
    rdy_mode = 0;
    send_sym(2, NP, 1'b1, 0);
    send_sym(3, NP, 1'b0, 0);
    repeat (5) @(negedge clk);
    check(in_ready == 1'b0, "R5 both banks full", in_ready, 0);
    fork
      send_sym(4, NP, 1'b1, 0);
      begin repeat (12) @(negedge clk); rdy_mode = 1; end
    join
    wait_empty();

    phase = "R5 overlap";
    rdy_mode = 1;
    for (int s = 5; s < 9; s++) send_sym(s, NP, 1'b1, 0);
    wait_empty();

    phase = "R6 R8 random";
    rdy_mode = 2;
    for (int s = 9; s < 15; s++) send_sym(s, NP, s[0], s % 3);
    wait_empty();

    phase = "R7 realign";
    rdy_mode = 1;
    send_sym(20, 25, 1'b1, 0);
    send_sym(21, NP, 1'b1, 0);
    send_sym(22, 40, 1'b0, 1);
    send_sym(23, NP, 1'b1, 0);
    wait_empty();
    check(out_valid == 1'b0, "R7 no extra symbol", out_valid, 0);

    repeat (5) @(negedge clk);
    summary();
    $finish;
  end

endmodule